// File: doc/BRIEF.md
# Looping Pattern Playback Buffer

This block stores a data pattern in an on-chip dual-port RAM and replays it without end. A host first clears the load state and then writes words into the buffer at any addresses it chooses. The highest address written since the clear sets the loop end, and the loop spans word 0 through that address. When the run control is raised, the block reads the buffer from its read pointer, one word per cycle. After the loop end it wraps straight back to word 0 and never needs the data loaded again.

The read pointer has two dedicated controls. One returns the pointer to the loop start. The other loads the pointer from an address input. A loaded address that lies past the loop end is forced to the loop start. While the pattern plays, the write port is locked: any write that arrives is dropped and raises a sticky error flag. That flag stays set until the next load clear or reset.

The buffer depth and the word width are parameters. The read data path has one register stage, so a word appears on the output one cycle after the read pointer addresses it.

Top module: `pattern_loop_buffer`

## Requirements
- R1: After reset, `pat_valid` and `wr_err` are 0, and no words count as loaded.
- R2: A write with `run` low stores `wr_data` at `wr_addr`. The loop end is the highest address written since the last clear or reset, not the most recent one, and the loop length is that address plus one.
- R3: While `run` is high and words are loaded, the block reads the word at the read pointer on each rising edge and presents it on `pat_data` with `pat_valid` high after that edge. The pointer steps by one and goes from the loop end back to 0, and `pat_valid` stays high through the wrap with no gap.
- R4: If no word has been loaded, `run` has no effect and `pat_valid` stays 0.
- R5: Dropping `run` makes `pat_valid` 0 from the next edge and holds the read pointer. Raising `run` again continues with the next word in the sequence.
- R6: A write while the pattern plays (`run` high with words loaded) leaves the buffer unchanged and sets `wr_err` on the next edge. `wr_err` then stays 1 until `ld_clear` or reset.
- R7: `ptr_zero` sets the read pointer to 0 and takes priority over `ptr_load`. On an edge where either pointer control is high, no word is read, so `pat_valid` is 0 after that edge. The next word played is word 0.
- R8: `ptr_load` sets the read pointer to `ptr_addr` if `ptr_addr` is not above the loop end. Otherwise it sets the pointer to 0.
- R9: `ld_clear` discards the loaded length, clears `wr_err` and sets the read pointer to 0. A write in the same cycle is dropped. The buffer contents are kept.
- R10: A loop of one word (only address 0 written) outputs that word on every cycle while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_clear | input | 1 | Clears the loaded length, error flag and read pointer before a new load |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address (AW = clog2(DEPTH)) |
| wr_data | input | DATA_W | Write data |
| run | input | 1 | Playback enable |
| ptr_zero | input | 1 | Sets the read pointer to the loop start |
| ptr_load | input | 1 | Loads the read pointer from `ptr_addr` |
| ptr_addr | input | AW | Address for `ptr_load` |
| pat_data | output | DATA_W | Played word |
| pat_valid | output | 1 | `pat_data` holds a word played on the last edge |
| wr_err | output | 1 | Sticky flag: a write was dropped during playback |

## Verification
The bench plays the pattern across several wraps. A design that restarted late or stalled at the loop end would show a gap in `pat_valid` or a repeated word. It loads the addresses out of order, so a design that took the most recent address as the loop end would play a short loop. Other tests cover these cases, each with the fault it catches:
- A write during playback: the bench confirms the buffer still replays the old word, which catches a design that lets the write through.
- A preset past the loop end: a design without the clamp would read stale words beyond the loop.
- A pause and resume: a design that kept advancing the pointer during the pause would skip words.
- Running an empty buffer and a one-word loop: these are the two length extremes.

// File: rtl/pattern_loop_buffer.sv
module pattern_loop_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_clear,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              run,
  input  logic              ptr_zero,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_addr,
  output logic [DATA_W-1:0] pat_data,
  output logic              pat_valid,
  output logic              wr_err
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              loaded;
  logic [AW-1:0]     loop_end;
  logic [AW-1:0]     rd_ptr;

  wire active  = run && loaded;
  wire ptr_ctl = ptr_zero || ptr_load;
  wire wr_ok   = wr_en && !active && !ld_clear;
  wire rd_go   = active && !ptr_ctl && !ld_clear;

  wire [AW-1:0] preset = (ptr_zero || ptr_addr > loop_end) ? '0 : ptr_addr;
  wire [AW-1:0] stepped = (rd_ptr == loop_end) ? '0 : rd_ptr + 1'b1;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk)
    if (rd_go) pat_data <= mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded    <= 1'b0;
      loop_end  <= '0;
      rd_ptr    <= '0;
      pat_valid <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      pat_valid <= rd_go;
      if (ld_clear) begin
        loaded   <= 1'b0;
        loop_end <= '0;
        rd_ptr   <= '0;
        wr_err   <= 1'b0;
      end else begin
        if (wr_ok) begin
          loaded <= 1'b1;
          if (!loaded || wr_addr > loop_end) loop_end <= wr_addr;
        end
        if (wr_en && active) wr_err <= 1'b1;
        if (ptr_ctl)    rd_ptr <= preset;
        else if (rd_go) rd_ptr <= stepped;
      end
    end
  end

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rd_ptr == loop_end) |=> rd_ptr == '0);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rd_ptr != loop_end) |=> rd_ptr == $past(rd_ptr) + 1'b1);

  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> !pat_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ptr_ctl && !ld_clear) |=> $stable(rd_ptr));

  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && active && !ld_clear) |=> wr_err);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !ld_clear) |=> wr_err);

  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_zero && !ld_clear) |=> (rd_ptr == '0 && !pat_valid));

  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> rd_ptr <= loop_end);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ld_clear |=> (!wr_err && !loaded && rd_ptr == '0));

endmodule

// File: tb/test_pattern_loop_buffer.sv
module test_pattern_loop_buffer;
  localparam int DW = 32;
  localparam int DEPTH = 2048;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, ld_clear = 0, wr_en = 0, run = 0;
  logic ptr_zero = 0, ptr_load = 0;
  logic [AW-1:0] wr_addr = '0, ptr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] pat_data;
  logic pat_valid, wr_err;

  int nchk = 0, nfail = 0, cyc = 0, idx = 0, len = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [16];

  pattern_loop_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) i_pattern_loop_buffer (
    .clk, .rst_n, .ld_clear, .wr_en, .wr_addr, .wr_data, .run,
    .ptr_zero, .ptr_load, .ptr_addr, .pat_data, .pat_valid, .wr_err);

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int i);
    return 32'hC3A50000 ^ (i * 32'h01030507);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
    exp_mem[a] = d;
    if (a + 1 > len) len = a + 1;
  endtask

  task automatic clear();
    ld_clear = 1; tick(); ld_clear = 0; len = 0; idx = 0;
  endtask

  task automatic play(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      tick();
      check(pat_valid == 1'b1, {tag, " valid"}, DW'(pat_valid), 1);
      check(pat_data == exp_mem[idx], {tag, " data"}, pat_data, exp_mem[idx]);
      idx = (idx + 1) % len;
    end
  endtask

  task automatic t_reset();
    check(pat_valid == 0, "R1 valid", DW'(pat_valid), 0);
    check(wr_err == 0, "R1 err", DW'(wr_err), 0);
  endtask

  task automatic t_empty_run();
    run = 1;
    for (int k = 0; k < 4; k++) begin
      tick();
      check(pat_valid == 0, "R4 empty run", DW'(pat_valid), 0);
    end
    run = 0; tick();
  endtask

  task automatic t_loop();
    for (int a = 0; a < 5; a++) wr(a, pat(a));
    run = 1;
    play(13, "R3 loop wrap");
  endtask

  task automatic t_pause();
    run = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(pat_valid == 0, "R5 paused", DW'(pat_valid), 0);
    end
    run = 1;
    play(6, "R5 resume");
  endtask

  task automatic t_write_busy();
    wr_en = 1; wr_addr = 2; wr_data = 32'hDEADBEEF;
    play(1, "R6 play during write");
    wr_en = 0;
    check(wr_err == 1, "R6 err set", DW'(wr_err), 1);
    play(len + 2, "R6 buffer unchanged");
    run = 0; tick(); tick();
    check(wr_err == 1, "R6 err sticky", DW'(wr_err), 1);
  endtask

  task automatic t_ptr();
    ptr_load = 1; ptr_addr = 3; tick(); ptr_load = 0;
    check(pat_valid == 0, "R7 no read on preset", DW'(pat_valid), 0);
    idx = 3; run = 1;
    play(4, "R8 preset in range");
    run = 0; tick();
    ptr_load = 1; ptr_addr = 9; tick(); ptr_load = 0;
    idx = 0; run = 1;
    play(2, "R8 preset clamped");
    ptr_zero = 1; ptr_load = 1; ptr_addr = 4; tick();
    ptr_zero = 0; ptr_load = 0;
    check(pat_valid == 0, "R7 zero gap", DW'(pat_valid), 0);
    idx = 0;
    play(3, "R7 zero wins");
    run = 0; tick();
  endtask

  task automatic t_clear();
    ld_clear = 1; wr_en = 1; wr_addr = 7; wr_data = 32'h12345678;
    tick();
    ld_clear = 0; wr_en = 0; len = 0; idx = 0;
    check(wr_err == 0, "R9 err cleared", DW'(wr_err), 0);
    run = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(pat_valid == 0, "R9 length discarded", DW'(pat_valid), 0);
    end
    run = 0; tick();
    wr(3, 32'h0000AAAA);
    wr(1, 32'h0000BBBB);
    check(len == 4, "R2 len model", DW'(len), 4);
    idx = 0; run = 1;
    play(10, "R2 highest address end");
    run = 0; tick();
  endtask

  task automatic t_single();
    clear();
    wr(0, 32'h5A5A0001);
    run = 1;
    play(5, "R10 one word loop");
    run = 0; tick();
  endtask

  initial begin
    for (int a = 0; a < 16; a++) exp_mem[a] = pat(a);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_empty_run();
    t_loop();
    t_pause();
    t_write_busy();
    t_ptr();
    t_clear();
    t_single();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule